// File: doc/BRIEF.md
# Dither Amplitude Ramp Generator

This block produces a signed offset that a PWM stage adds to its duty value, so that the output duty swings up and down around its nominal value. The size of the swing is an envelope. The envelope does not switch on or off at once: it fades in over a programmable ramp-up time when the dither request bit rises, and fades out over a separate ramp-down time when the request bit falls. Under the envelope, a symmetric square wave alternates between plus and minus the current envelope value. The length of each half of the square wave is half the programmed dither period.

The amplitude is given in percent. The dither period is given in microseconds. Both ramp times are 16-bit values in milliseconds. A free-running microsecond timebase drives the square wave. A millisecond counter, which restarts at every request edge, paces the envelope. At each request edge a serial divider works out the envelope increment per millisecond. It finishes well before the first millisecond tick that follows. The block does not load the parameters and does not generate the PWM.

Top module: `dither_ramp_gen`

## Requirements
- R1: After reset, `duty_ofs` is 0 and `dither_active` is 0.
- R2: A 0-to-1 change of `dither_req` raises `dither_active` in the clock cycle after the change is sampled. The same edge captures `amp_pct` and `ramp_up_ms`.
- R3: After a rising edge, the k-th millisecond tick (US_PER_MS microseconds apart, first one US_PER_MS microseconds after the edge) sets the envelope to min(E0 + k·S, A·2^16). Here E0 is the envelope at the edge, A is the captured amplitude, and S = ceil(A·2^16 / T) for ramp-up time T ≥ 1.
- R4: A ramp-up time of 0 uses S = A·2^16, so the envelope reaches full amplitude at the first tick.
- R5: After a falling edge, each millisecond tick lowers the envelope by ceil(A·2^16 / D) and stops at 0. D is the ramp-down time captured at the falling edge, and a value of 0 counts as 1, which gives a single step. A is still the amplitude captured at the last rising edge.
- R6: `dither_active` stays 1 until the tick at which a ramp-down brings the envelope to 0. It is 0 from then on, and `duty_ofs` is 0 whenever `dither_active` is 0.
- R7: A request edge during a ramp starts the new ramp from the envelope value reached so far. It does not restart from zero or from full scale.
- R8: The square wave is positive while the block is inactive. Counting from the rising edge that activates the block, it changes sign every H microseconds, where H = max(floor(`period_us`/2), 1).
- R9: `duty_ofs` is two's complement. Its magnitude is the envelope shifted right by 16−OFS_FRAC bits, which gives percent with OFS_FRAC fraction bits. Its sign is negative during the negative half of the square wave.
- R10: Changes to `amp_pct` after a rising edge have no effect on the envelope until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dither_req | input | 1 | Dither request level; its edges start the ramps |
| amp_pct | input | AMP_W | Dither amplitude in percent |
| period_us | input | PER_W | Dither period in microseconds |
| ramp_up_ms | input | TIME_W | Fade-in time in milliseconds |
| ramp_dn_ms | input | TIME_W | Fade-out time in milliseconds |
| duty_ofs | output | AMP_W+OFS_FRAC+1 | Signed duty offset, percent with OFS_FRAC fraction bits |
| dither_active | output | 1 | High from the request's rising edge until the envelope has faded to zero |

## Verification
The bench sweeps several amplitude and ramp-time pairs and compares the offset after every millisecond tick with the exact ceiling-divided step. A design that rounds the step down would need one tick too many to reach full scale, and that shows up as a miscompare at the final ramp tick. The ramps also cover zero ramp times, zero amplitude, and a change of amplitude after the rising edge; a design that reads the amplitude live would shrink the envelope in the middle of the ramp. Reversals in the middle of a ramp, in both directions, would expose a design that resets the envelope to zero or to full scale. Square-wave sweeps cycle by cycle with even, odd and one-microsecond periods catch an off-by-one half length or a first half that starts out negative.

// File: rtl/dr_pkg.sv
// Shared types for the dither ramp generator.
package dr_pkg;

    // Envelope phase: at rest, fading in, held at full, fading out.
    typedef enum logic [1:0] {
        ENV_IDLE = 2'd0,
        ENV_UP   = 2'd1,
        ENV_FULL = 2'd2,
        ENV_DOWN = 2'd3
    } env_state_t;

endpackage

// File: rtl/dr_usec_tick.sv
// Microsecond strobe from the system clock.
// Assumes CLK_PER_US >= 1. A value of 1 gives a strobe on every cycle.
module dr_usec_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (CLK_PER_US <= 1) begin : g_direct
            // One microsecond per clock: the strobe is always present.
            always_comb tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CLK_PER_US);
            logic [CW-1:0] cnt;

            // Free-running prescaler that wraps once per microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else        cnt <= (cnt == CW'(CLK_PER_US - 1)) ? '0 : cnt + 1'b1;
            end

            // Strobe on the last count of each microsecond.
            always_comb tick = (cnt == CW'(CLK_PER_US - 1));
        end
    endgenerate

endmodule

// File: rtl/dr_step_div.sv
// Serial restoring divider: one quotient bit per cycle, DVD_W cycles in total.
// Assumes divisor != 0. A new start aborts any division in progress.
// quot is valid once busy is low.
module dr_step_div #(
    parameter int DVD_W = 23,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic [DVD_W-1:0] quot
);

    localparam int CW = $clog2(DVD_W + 1);

    logic [DVS_W-1:0] rem;
    logic [DVS_W-1:0] dvs_q;
    logic [CW-1:0]    cnt;
    logic [DVS_W:0]   rem_sh;
    logic             ge;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem, quot[DVD_W-1]};
        ge     = (rem_sh >= {1'b0, dvs_q});
    end

    // Shift the dividend through the quotient register, one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            quot  <= '0;
            rem   <= '0;
            dvs_q <= '0;
            cnt   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            quot  <= dividend;
            rem   <= '0;
            dvs_q <= divisor;
            cnt   <= CW'(DVD_W);
        end else if (busy) begin
            quot <= {quot[DVD_W-2:0], ge};
            rem  <= ge ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/dr_envelope.sv
// Envelope ramp: fades a fixed-point amplitude (FRAC fraction bits) in and out.
// Each edge of req restarts the millisecond counter and starts a division for
// the per-tick step. Assumes the division (AMP_W+FRAC cycles) ends before the
// first millisecond tick after an edge.
module dr_envelope #(
    parameter int AMP_W     = 7,
    parameter int TIME_W    = 16,
    parameter int FRAC      = 16,
    parameter int OFS_FRAC  = 4,
    parameter int US_PER_MS = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      us_tick,
    input  logic                      req,
    input  logic [AMP_W-1:0]          amp,
    input  logic [TIME_W-1:0]         t_up,
    input  logic [TIME_W-1:0]         t_dn,
    output logic                      active,
    output logic [AMP_W+OFS_FRAC-1:0] mag
);
    import dr_pkg::*;

    localparam int ENV_W = AMP_W + FRAC;
    localparam int MSC_W = $clog2(US_PER_MS + 1);

    env_state_t       st;
    logic             req_q;
    logic             rise, fall;
    logic [ENV_W-1:0] env_q;
    logic [AMP_W-1:0] amp_lat;
    logic [MSC_W-1:0] ms_cnt;
    logic             ms_wrap, ms_tick;
    logic [AMP_W-1:0] a_sel;
    logic [TIME_W-1:0] t_sel, dvs;
    logic [ENV_W-1:0] dividend;
    logic [ENV_W-1:0] step;
    logic             div_busy;
    logic [ENV_W-1:0] target;
    logic [ENV_W:0]   up_sum;
    logic [ENV_W-1:0] up_next, dn_next;

    // Edge detection on the request level.
    always_comb begin
        rise = req & ~req_q;
        fall = ~req & req_q;
    end

    // Millisecond strobe from the microsecond strobe.
    always_comb begin
        ms_wrap = (ms_cnt == MSC_W'(US_PER_MS - 1));
        ms_tick = us_tick & ms_wrap;
    end

    // Step operands: ceil(amp * 2^FRAC / t), where a time of 0 is treated as 1.
    always_comb begin
        a_sel    = rise ? amp : amp_lat;
        t_sel    = rise ? t_up : t_dn;
        dvs      = (t_sel == '0) ? TIME_W'(1) : t_sel;
        dividend = {a_sel, {FRAC{1'b0}}} + ENV_W'(dvs) - ENV_W'(1);
    end

    dr_step_div #(
        .DVD_W (ENV_W),
        .DVS_W (TIME_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rise | fall),
        .dividend (dividend),
        .divisor  (dvs),
        .busy     (div_busy),
        .quot     (step)
    );

    // Next envelope values for a step up (saturating) and a step down (floored at 0).
    always_comb begin
        target  = {amp_lat, {FRAC{1'b0}}};
        up_sum  = {1'b0, env_q} + {1'b0, step};
        up_next = (up_sum >= {1'b0, target}) ? target : up_sum[ENV_W-1:0];
        dn_next = (env_q > step) ? (env_q - step) : '0;
    end

    // Ramp state, envelope and timebase. A request edge takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            st      <= ENV_IDLE;
            env_q   <= '0;
            amp_lat <= '0;
            ms_cnt  <= '0;
        end else begin
            req_q <= req;
            if (rise) begin
                st      <= ENV_UP;
                amp_lat <= amp;
                ms_cnt  <= '0;
            end else if (fall) begin
                st     <= ENV_DOWN;
                ms_cnt <= '0;
            end else begin
                if (us_tick) ms_cnt <= ms_wrap ? '0 : ms_cnt + 1'b1;
                if (ms_tick) begin
                    case (st)
                        ENV_UP: begin
                            env_q <= up_next;
                            if (up_next == target) st <= ENV_FULL;
                        end
                        ENV_DOWN: begin
                            env_q <= dn_next;
                            if (dn_next == '0) st <= ENV_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Status and output magnitude.
    always_comb begin
        active = (st != ENV_IDLE);
        mag    = env_q[ENV_W-1:FRAC-OFS_FRAC];
    end

    // R3
    div_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> !div_busy);

    // R2
    rise_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> active);

    // R5
    dn_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_DOWN && !rise) |=> (env_q <= $past(env_q)));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_IDLE) |-> (env_q == '0));

endmodule

// File: rtl/dr_square_wave.sv
// Square-wave sign: flips every max(period/2, 1) microseconds while active.
// Restarts positive whenever inactive. period may change at any time; the new
// half length is used from the next comparison on.
module dr_square_wave #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             active,
    input  logic [PER_W-1:0] period_us,
    output logic             neg
);

    logic [PER_W-1:0] half, last;
    logic [PER_W-1:0] cnt;

    // Last count value of a half period.
    always_comb begin
        half = period_us >> 1;
        last = (half == '0) ? '0 : half - 1'b1;
    end

    // Half-period counter and sign toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
            neg <= 1'b0;
        end else if (us_tick) begin
            if (cnt >= last) begin
                cnt <= '0;
                neg <= ~neg;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8
    wave_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !neg);

endmodule

// File: rtl/dither_ramp_gen.sv
// Dither offset generator: an envelope that fades in and out, applied to a
// symmetric square wave. The output is a signed duty offset in percent with
// OFS_FRAC fraction bits. Assumes AMP_W+FRAC < CLK_PER_US*US_PER_MS.
module dither_ramp_gen #(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int AMP_W      = 7,
    parameter int TIME_W     = 16,
    parameter int PER_W      = 16,
    parameter int FRAC       = 16,
    parameter int OFS_FRAC   = 4,
    localparam int OFS_W     = AMP_W + OFS_FRAC + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dither_req,
    input  logic [AMP_W-1:0]        amp_pct,
    input  logic [PER_W-1:0]        period_us,
    input  logic [TIME_W-1:0]       ramp_up_ms,
    input  logic [TIME_W-1:0]       ramp_dn_ms,
    output logic signed [OFS_W-1:0] duty_ofs,
    output logic                    dither_active
);

    logic                      us_tick;
    logic                      neg;
    logic [AMP_W+OFS_FRAC-1:0] mag;
    logic signed [OFS_W-1:0]   mag_s;

    dr_usec_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    dr_envelope #(
        .AMP_W     (AMP_W),
        .TIME_W    (TIME_W),
        .FRAC      (FRAC),
        .OFS_FRAC  (OFS_FRAC),
        .US_PER_MS (US_PER_MS)
    ) u_env (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .req     (dither_req),
        .amp     (amp_pct),
        .t_up    (ramp_up_ms),
        .t_dn    (ramp_dn_ms),
        .active  (dither_active),
        .mag     (mag)
    );

    dr_square_wave #(.PER_W(PER_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .active    (dither_active),
        .period_us (period_us),
        .neg       (neg)
    );

    // Apply the wave sign to the envelope magnitude.
    always_comb begin
        mag_s    = $signed({1'b0, mag});
        duty_ofs = neg ? -mag_s : mag_s;
    end

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dither_active |-> (duty_ofs == '0));

endmodule

// File: tb/sim_dither_ramp_gen.sv
module sim_dither_ramp_gen;

    localparam int US_PER_MS = 32;
    localparam int FRAC      = 16;
    localparam int OFS_FRAC  = 4;
    localparam int SHIFT     = FRAC - OFS_FRAC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dither_req = 1'b0;
    logic [6:0]        amp_pct = '0;
    logic [15:0]       period_us = 16'hFFFF;
    logic [15:0]       ramp_up_ms = '0;
    logic [15:0]       ramp_dn_ms = '0;
    logic signed [11:0] duty_ofs;
    logic              dither_active;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dither_ramp_gen #(
        .CLK_PER_US (1),
        .US_PER_MS  (US_PER_MS),
        .FRAC       (FRAC),
        .OFS_FRAC   (OFS_FRAC)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .dither_req    (dither_req),
        .amp_pct       (amp_pct),
        .period_us     (period_us),
        .ramp_up_ms    (ramp_up_ms),
        .ramp_dn_ms    (ramp_dn_ms),
        .duty_ofs      (duty_ofs),
        .dither_active (dither_active)
    );

    function automatic longint ceil_step(input longint a, input longint t);
        longint d = (t == 0) ? 1 : t;
        return ((a << FRAC) + d - 1) / d;
    endfunction

    task automatic check(input string tag, input longint env, input bit neg, input bit act);
        int exp_ofs = int'(env >> SHIFT);
        int got_ofs = int'(duty_ofs);
        if (neg) exp_ofs = -exp_ofs;
        vectors++;
        if (got_ofs != exp_ofs || dither_active != act) begin
            miscompares++;
            $display("FAIL %s: ofs=%0d active=%0b, expected ofs=%0d active=%0b",
                     tag, got_ofs, dither_active, exp_ofs, act);
        end
    endtask

    // Wait for the next millisecond tick, then sample.
    task automatic tick_check(input string tag, input longint env, input bit act);
        repeat (US_PER_MS) @(posedge clk);
        @(negedge clk);
        check(tag, env, 1'b0, act);
    endtask

    // Apply a request edge at a negedge and check the cycle after it.
    task automatic edge_to(input bit lvl, input int a, input int t, input longint env_now);
        amp_pct = 7'(a);
        if (lvl) ramp_up_ms = 16'(t); else ramp_dn_ms = 16'(t);
        dither_req = lvl;
        @(posedge clk);
        @(negedge clk);
        check(lvl ? "R2 rise" : "R6 fall", env_now, 1'b0, 1'b1);
    endtask

    // Full fade-in, hold and fade-out, with an optional change of the amplitude input.
    task automatic ramp_cycle(input int a, input int tu, input int td, input bit poke);
        longint full = longint'(a) << FRAC;
        longint su = ceil_step(a, tu);
        longint sd = ceil_step(a, td);
        longint env = 0;
        int nup = ((tu == 0) ? 1 : tu) + 1;
        int ndn = ((td == 0) ? 1 : td) + 1;
        edge_to(1'b1, a, tu, 0);
        if (poke) amp_pct = 7'd3;  // R10: must not affect the envelope
        for (int k = 1; k <= nup; k++) begin
            env = (env + su > full) ? full : env + su;
            tick_check(tu == 0 ? "R4 zero up" : (poke ? "R10 held amp" : "R3 up"), env, 1'b1);
        end
        edge_to(1'b0, a, td, env);
        for (int j = 1; j <= ndn; j++) begin
            env = (env > sd) ? env - sd : 0;
            tick_check(td == 0 ? "R5 zero down" : "R5 down", env, env != 0);
            if (env == 0) break;
        end
        tick_check("R6 idle", 0, 1'b0);
    endtask

    // Square-wave sign sweep, cycle by cycle, at full amplitude.
    task automatic wave_sweep(input int p);
        int h = (p / 2 == 0) ? 1 : p / 2;
        longint full = longint'(50) << FRAC;
        period_us = 16'(p);
        edge_to(1'b1, 50, 0, 0);
        tick_check("R4 wave start", full, 1'b1);  // sample after cycle 32
        for (int n = US_PER_MS + 1; n <= US_PER_MS + 40; n++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8/R9 wave", full, ((n / h) % 2) == 1, 1'b1);
        end
        dither_req = 1'b0;
        ramp_dn_ms = '0;
        repeat (US_PER_MS + 1) @(posedge clk);
        @(negedge clk);
        check("R6 wave end", 0, 1'b0, 1'b0);
        period_us = 16'hFFFF;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0, 1'b0, 1'b0);

        ramp_cycle(40, 5, 3, 1'b0);
        ramp_cycle(100, 0, 0, 1'b0);
        ramp_cycle(7, 9, 4, 1'b1);
        ramp_cycle(100, 3, 7, 1'b0);
        ramp_cycle(0, 2, 2, 1'b0);
        ramp_cycle(1, 1, 6, 1'b0);

        // R7: reversals in the middle of a ramp continue from the current envelope.
        begin
            longint s10 = ceil_step(60, 10);
            longint s5 = ceil_step(60, 5);
            longint env = 0;
            edge_to(1'b1, 60, 10, 0);
            for (int k = 1; k <= 4; k++) begin
                env += s10;
                tick_check("R7 up part", env, 1'b1);
            end
            edge_to(1'b0, 60, 10, env);
            for (int j = 1; j <= 2; j++) begin
                env -= s10;
                tick_check("R7 down from partial", env, 1'b1);
            end
            edge_to(1'b1, 60, 10, env);
            for (int k = 1; k <= 2; k++) begin
                env += s10;
                tick_check("R7 up from partial", env, 1'b1);
            end
            edge_to(1'b0, 60, 5, env);
            for (int j = 1; j <= 4; j++) begin
                env = (env > s5) ? env - s5 : 0;
                tick_check("R7 final down", env, env != 0);
                if (env == 0) break;
            end
        end

        wave_sweep(8);
        wave_sweep(5);
        wave_sweep(1);
        wave_sweep(0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule